// File: doc/BRIEF.md
# Cartridge Bank Mapping Register File

This block listens on a CPU write bus and holds the bank numbers a cartridge uses to place slices of its program and character ROM into the console's address spaces. A write to a fixed window of byte registers updates one bank select. Purely combinational logic then turns each live CPU or PPU address into a physical ROM address.

The CPU side has one fixed layout. A 16 KiB window sits at 0x8000–0xBFFF. Two 8 KiB windows follow at 0xC000 and 0xE000. The PPU pattern space is split into eight 1 KiB slots. A separate register carries four 2-bit nametable source selects for the mirroring logic downstream. The two mode registers at the bottom of the window are assumed to stay at their fixed values (2 and 3 in the low bits), so they are given no storage and no output.

Top module: `bankmap_top`

## Requirements
- R1: After reset the 16 KiB program bank is 0x3F, both 8 KiB program banks are 0x7F, all eight character banks are 0 and the nametable select output is 0.
- R2: Only writes with the write strobe high and an address from 0x5100 to 0x512F inclusive can change state. Writes below or above that range leave every output unchanged, and so does bus activity with the strobe low.
- R3: A write to offset 0x05 sets `ntSel`. Bits [2q+1:2q] of the written byte are the source select for nametable quadrant q, for q = 0..3.
- R4: A write to offset 0x15 loads data bits 6:1 as the 16 KiB bank. For CPU addresses 0x8000–0xBFFF, `prgAddr` = {bank[5:0], cpuAddr[13:0]}.
- R5: Writes to offsets 0x16 and 0x17 load data bits 6:0 as the 8 KiB banks for 0xC000–0xDFFF and 0xE000–0xFFFF. `prgAddr` = {bank[6:0], cpuAddr[12:0]} in either window.
- R6: Offsets 0x20–0x23 load character slots 0–3 and offsets 0x28–0x2B load slots 4–7, taking the full data byte. `chrAddr` = {slotBank[7:0], ppuAddr[9:0]}, where ppuAddr[12:10] picks the slot.
- R7: Writes to offsets inside the window that have no function (for example 0x00, 0x14, 0x24–0x27) change no output.
- R8: While cpuAddr[15] is 0, `prgValid` is 0 and `prgAddr` is 0. While cpuAddr[15] is 1, `prgValid` is 1.
- R9: A write takes effect at the rising edge where the strobe is sampled high. Before that edge the outputs still show the old bank. From that edge on they show the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuWrEn | input | 1 | CPU write strobe |
| cpuAddr | input | 16 | CPU address, used for writes and for translation |
| cpuWrData | input | 8 | CPU write data |
| ppuAddr | input | 13 | PPU pattern-table address |
| prgAddr | output | 20 | Physical program ROM address |
| prgValid | output | 1 | CPU address lies in the banked program range |
| chrAddr | output | 18 | Physical character ROM address |
| ntSel | output | 8 | Four 2-bit nametable source selects |

## Verification
The bench builds the block with its default parameters: a 48-register window at 0x5100, eight 8-bit character slots, and 6-bit and 7-bit program banks. These defaults reach both window edges, 0x50FF and 0x5130. They also reach all eight non-contiguous character offsets and the holes between them. With these settings the 16 KiB and 8 KiB translations both produce full 20-bit addresses, so a dropped or shifted bank bit appears directly on `prgAddr`.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;
  localparam int CHR_SLOTS = 8;

  // Register offsets relative to the window base
  localparam logic [5:0] OFF_MIRROR = 6'h05;
  localparam logic [5:0] OFF_PRG16  = 6'h15;
  localparam logic [5:0] OFF_PRGC   = 6'h16;
  localparam logic [5:0] OFF_PRGE   = 6'h17;
  localparam logic [5:0] OFF_CHR_LO = 6'h20;  // slots 0..3
  localparam logic [5:0] OFF_CHR_HI = 6'h28;  // slots 4..7

  typedef struct packed {
    logic                 mirror;
    logic                 prg16;
    logic                 prgC;
    logic                 prgE;
    logic [CHR_SLOTS-1:0] chr;
  } wrStrobe_t;
endpackage

// File: rtl/bankmap_ctrl.sv
module bankmap_ctrl
  import bankmap_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'h5100,
  parameter int          REG_COUNT = 48
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [15:0] addr,
  output wrStrobe_t  strobe
);
  localparam int OFF_W = $clog2(REG_COUNT);

  logic [15:0]          diff;
  logic                 inWin;
  logic [OFF_W-1:0]     off;
  logic [CHR_SLOTS-1:0] chrHit;

  assign diff  = addr - BASE_ADDR;
  assign inWin = wrEn && (addr >= BASE_ADDR) && (diff < 16'(REG_COUNT));
  assign off   = diff[OFF_W-1:0];

  // Slot i decodes at the low or high group, lane i%4
  for (genvar i = 0; i < CHR_SLOTS; i++) begin : g_chrDec
    localparam logic [5:0] SLOT_OFF =
      ((i / 4) == 0 ? OFF_CHR_LO : OFF_CHR_HI) + 6'(i % 4);
    assign chrHit[i] = inWin && (off == OFF_W'(SLOT_OFF));
  end

  always_comb begin
    strobe        = '0;
    strobe.chr    = chrHit;
    strobe.mirror = inWin && (off == OFF_W'(OFF_MIRROR));
    strobe.prg16  = inWin && (off == OFF_W'(OFF_PRG16));
    strobe.prgC   = inWin && (off == OFF_W'(OFF_PRGC));
    strobe.prgE   = inWin && (off == OFF_W'(OFF_PRGE));
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe)) else $error("more than one register strobed"); // R6

  AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn || addr < BASE_ADDR || addr >= BASE_ADDR + 16'(REG_COUNT)) |-> (strobe == '0))
    else $error("strobe outside window"); // R2
endmodule

// File: rtl/bankmap_dp.sv
module bankmap_dp
  import bankmap_pkg::*;
#(
  parameter int PRG16_W = 6,
  parameter int PRG8_W  = 7,
  parameter int CHR_W   = 8,
  localparam int SLOT_W = $clog2(CHR_SLOTS),
  localparam int PPU_AW = SLOT_W + 10,
  localparam int PRG_AW = (PRG16_W + 14 > PRG8_W + 13) ? PRG16_W + 14 : PRG8_W + 13,
  localparam int CHR_AW = CHR_W + 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strobe,
  input  logic [7:0]        wrData,
  input  logic [15:0]       cpuAddr,
  input  logic [PPU_AW-1:0] ppuAddr,
  output logic [PRG_AW-1:0] prgAddr,
  output logic              prgValid,
  output logic [CHR_AW-1:0] chrAddr,
  output logic [7:0]        ntSel
);
  logic [7:0]         ntReg;
  logic [PRG16_W-1:0] prg16Bank;
  logic [PRG8_W-1:0]  prgCBank;
  logic [PRG8_W-1:0]  prgEBank;
  logic [CHR_W-1:0]   chrBank [CHR_SLOTS];

  // Program banks reset to all ones (0x7F written, 16 KiB takes bits 6:1)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ntReg     <= '0;
      prg16Bank <= '1;
      prgCBank  <= '1;
      prgEBank  <= '1;
    end else begin
      if (strobe.mirror) ntReg     <= wrData;
      if (strobe.prg16)  prg16Bank <= wrData[PRG16_W:1];
      if (strobe.prgC)   prgCBank  <= wrData[PRG8_W-1:0];
      if (strobe.prgE)   prgEBank  <= wrData[PRG8_W-1:0];
    end
  end

  for (genvar i = 0; i < CHR_SLOTS; i++) begin : g_chr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              chrBank[i] <= '0;
      else if (strobe.chr[i]) chrBank[i] <= wrData[CHR_W-1:0];
    end

    AST_CHR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
      strobe.chr[i] |=> (chrBank[i] == $past(wrData[CHR_W-1:0])))
      else $error("character slot not loaded"); // R6
  end

  always_comb begin
    prgValid = cpuAddr[15];
    prgAddr  = '0;
    if (cpuAddr[15]) begin
      if (!cpuAddr[14])      prgAddr = PRG_AW'({prg16Bank, cpuAddr[13:0]});
      else if (!cpuAddr[13]) prgAddr = PRG_AW'({prgCBank, cpuAddr[12:0]});
      else                   prgAddr = PRG_AW'({prgEBank, cpuAddr[12:0]});
    end
  end

  assign chrAddr = {chrBank[ppuAddr[PPU_AW-1:10]], ppuAddr[9:0]};
  assign ntSel   = ntReg;

  AST_PRG16_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.prg16 |=> $stable(prg16Bank)) else $error("16K bank moved"); // R2

  AST_PRG_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[15] && !cpuAddr[14]) |-> (prgAddr[13:0] == cpuAddr[13:0]))
    else $error("16K offset bits wrong"); // R4

  AST_LOW_UNMAPPED: assert property (@(posedge clk) disable iff (!rstN)
    !cpuAddr[15] |-> (!prgValid && prgAddr == '0))
    else $error("low CPU space translated"); // R8
endmodule

// File: rtl/bankmap_top.sv
module bankmap_top
  import bankmap_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'h5100,
  parameter int          REG_COUNT = 48
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuWrEn,
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  cpuWrData,
  input  logic [12:0] ppuAddr,
  output logic [19:0] prgAddr,
  output logic        prgValid,
  output logic [17:0] chrAddr,
  output logic [7:0]  ntSel
);
  wrStrobe_t strobe;

  bankmap_ctrl #(.BASE_ADDR(BASE_ADDR), .REG_COUNT(REG_COUNT)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (cpuWrEn),
    .addr   (cpuAddr),
    .strobe (strobe)
  );

  bankmap_dp #(.PRG16_W(6), .PRG8_W(7), .CHR_W(8)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (cpuWrData),
    .cpuAddr  (cpuAddr),
    .ppuAddr  (ppuAddr),
    .prgAddr  (prgAddr),
    .prgValid (prgValid),
    .chrAddr  (chrAddr),
    .ntSel    (ntSel)
  );
endmodule

// File: tb/tb_bankmap_top.sv
module tb_bankmap_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuWrEn = 1'b0;
  logic [15:0] cpuAddr = 16'h0000;
  logic [7:0]  cpuWrData = 8'h00;
  logic [12:0] ppuAddr = 13'h0000;
  logic [19:0] prgAddr;
  logic        prgValid;
  logic [17:0] chrAddr;
  logic [7:0]  ntSel;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] chrModel [8];

  bankmap_top dut (.*);

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuWrEn = 1'b1; cpuAddr = a; cpuWrData = d;
    @(negedge clk);
    cpuWrEn = 1'b0;
  endtask

  task automatic probePrg(input logic [15:0] a);
    cpuAddr = a; #1;
  endtask

  task automatic probeChr(input int slot, input logic [9:0] low);
    ppuAddr = {3'(slot), low}; #1;
  endtask

  task automatic testReset();
    probePrg(16'h8000); check("R1 16K reset", 32'(prgAddr), 32'h FC000);
    probePrg(16'hC000); check("R1 C000 reset", 32'(prgAddr), 32'h FE000);
    probePrg(16'hE123); check("R1 E000 reset", 32'(prgAddr), 32'h FE123);
    check("R1 ntSel reset", 32'(ntSel), 32'h0);
    for (int i = 0; i < 8; i++) begin
      probeChr(i, 10'h155);
      check("R1 chr reset", 32'(chrAddr), 32'h155);
    end
  endtask

  task automatic testNametable();
    doWrite(16'h5105, 8'hE4); #1;
    check("R3 ntSel E4", 32'(ntSel), 32'hE4);
    doWrite(16'h5105, 8'h1B); #1;
    check("R3 ntSel 1B", 32'(ntSel), 32'h1B);
  endtask

  task automatic testPrg();
    doWrite(16'h5115, 8'h8B);
    probePrg(16'h9234); check("R4 16K map", 32'(prgAddr), 32'h15234);
    probePrg(16'hBFFF); check("R4 16K top", 32'(prgAddr), 32'h17FFF);
    doWrite(16'h5116, 8'h85);
    probePrg(16'hC010); check("R5 C000 map", 32'(prgAddr), 32'h0A010);
    doWrite(16'h5117, 8'hAA);
    probePrg(16'hFFFF); check("R5 E000 map", 32'(prgAddr), 32'h55FFF);
    probePrg(16'hDFFF); check("R5 C000 kept", 32'(prgAddr), 32'h0BFFF);
    check("R8 valid high", 32'(prgValid), 32'h1);
  endtask

  task automatic testChr();
    for (int i = 0; i < 8; i++) begin
      chrModel[i] = 8'(8'h10 + i * 8'h11 + 8'h80);
      doWrite(16'h5120 + 16'((i / 4) * 8 + (i % 4)), chrModel[i]);
    end
    for (int i = 0; i < 8; i++) begin
      probeChr(i, 10'h3A5);
      check("R6 chr slot", 32'(chrAddr), 32'({chrModel[i], 10'h3A5}));
    end
  endtask

  task automatic testIgnored();
    logic [19:0] p0, p1;
    logic [7:0] n0;
    probePrg(16'h8000); p0 = prgAddr;
    probePrg(16'hC000); p1 = prgAddr;
    n0 = ntSel;
    doWrite(16'h50FF, 8'h00);
    doWrite(16'h5130, 8'h00);
    doWrite(16'h5305, 8'h00);
    @(negedge clk); cpuWrEn = 1'b0; cpuAddr = 16'h5115; cpuWrData = 8'h00;
    @(negedge clk); cpuAddr = 16'h5116;
    @(negedge clk);
    probePrg(16'h8000); check("R2 outside 16K", 32'(prgAddr), 32'(p0));
    probePrg(16'hC000); check("R2 outside C000", 32'(prgAddr), 32'(p1));
    check("R2 outside nt", 32'(ntSel), 32'(n0));
    doWrite(16'h5100, 8'hFF);
    doWrite(16'h5114, 8'h00);
    for (int o = 4; o < 8; o++) doWrite(16'h5120 + 16'(o), 8'h00);
    for (int o = 12; o < 16; o++) doWrite(16'h5120 + 16'(o), 8'h00);
    probePrg(16'h8000); check("R7 hole 16K", 32'(prgAddr), 32'(p0));
    probePrg(16'hC000); check("R7 hole C000", 32'(prgAddr), 32'(p1));
    probePrg(16'hE000); check("R7 hole E000", 32'(prgAddr), 32'h54000);
    check("R7 hole nt", 32'(ntSel), 32'(n0));
    for (int i = 0; i < 8; i++) begin
      probeChr(i, 10'h001);
      check("R7 hole chr", 32'(chrAddr), 32'({chrModel[i], 10'h001}));
    end
  endtask

  task automatic testLowCpu();
    probePrg(16'h7FFF);
    check("R8 low valid", 32'(prgValid), 32'h0);
    check("R8 low addr", 32'(prgAddr), 32'h0);
    probePrg(16'h0000);
    check("R8 zero addr", 32'(prgAddr), 32'h0);
  endtask

  task automatic testTiming();
    @(negedge clk);
    cpuWrEn = 1'b1; cpuAddr = 16'h5116; cpuWrData = 8'h33;
    #1;
    cpuAddr = 16'h5116;
    // cpuAddr is the write address here, so look at the C000 bank via a quiet probe after
    @(posedge clk); #1;
    cpuWrEn = 1'b0;
    probePrg(16'hC000); check("R9 after edge", 32'(prgAddr), 32'h66000);
    @(negedge clk);
    cpuWrEn = 1'b1; cpuAddr = 16'h5105; cpuWrData = 8'h5A;
    #1; check("R9 before edge", 32'(ntSel), 32'h1B);
    @(posedge clk); #1;
    check("R9 at edge", 32'(ntSel), 32'h5A);
    cpuWrEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNametable();
    testPrg();
    testChr();
    testIgnored();
    testLowCpu();
    testTiming();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule